// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap fires. On a valid strobe it takes two operands and a five-bit condition mask, evaluates five relations between the operands (signed less, signed greater, equal, unsigned less, unsigned greater) and raises a trap flag when any relation selected by the mask holds. Several mask bits may be set at once, so the unit fires on any OR-combination of the tests.

A mode input chooses the operand width. In word mode only the low half of each operand takes part, read as signed or unsigned depending on the test. In doubleword mode the full operands are used. When a trap fires, the unit also presents a fixed program-exception reason code, so the exception logic downstream can record why the program stopped. Decoding the trap instruction and delivering the exception are left to neighbouring blocks.

Top module: `trap_cmp_unit`

## Requirements
- R1: `done_o` is high in exactly the cycle after a cycle in which `valid_i` is sampled high, and low otherwise.
- R2: Mask bit 4 (value 0x10) traps when operand A is less than operand B as signed numbers.
- R3: Mask bit 3 (value 0x08) traps when operand A is greater than operand B as signed numbers.
- R4: Mask bit 2 (value 0x04) traps when the compared operands are equal.
- R5: Mask bit 1 (value 0x02) traps when A is less than B as unsigned numbers, and mask bit 0 (value 0x01) traps when A is greater than B as unsigned numbers.
- R6: When several mask bits are set, the trap fires if any one of the selected relations holds.
- R7: With `dword_i` low (word mode), only bits 31:0 of each operand are compared; bits 63:32 have no effect on `trap_o`.
- R8: With `dword_i` high, all 64 bits of each operand are compared.
- R9: A mask of 0x00 never traps; a mask of 0x1F always traps.
- R10: `trap_o` is high only together with `done_o`; `cause_o` equals the trap reason code (default 0x3) while `trap_o` is high and is 0 otherwise.
- R11: While reset is asserted, `done_o`, `trap_o` and `cause_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Compare request strobe |
| dword_i | input | 1 | 1 = compare 64 bits, 0 = compare low 32 bits |
| mask_i | input | 5 | Condition mask selecting the trap relations |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| done_o | output | 1 | Result strobe, one cycle after `valid_i` |
| trap_o | output | 1 | Trap taken, qualified by `done_o` |
| cause_o | output | 4 | Program-exception reason code when trapping, else 0 |

## Verification
Every result (`done_o`, `trap_o` and `cause_o`) is registered once, so it appears on the clock edge that samples `valid_i` and must be read in the cycle after the request. The bench drives a request on a falling edge, waits for the next rising edge, and samples on the following falling edge. It then drops the strobe and, after one more rising edge, confirms that `done_o` and `trap_o` have cleared. The sweep covers every mask value, both widths and a set of boundary operands, with noise placed in the upper halves during word mode.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    localparam int MASK_W = 5;
    localparam int CODE_W = 4;

    // Field order fixes the mask bit each relation answers to.
    typedef struct packed {
        logic slt;   // mask bit 4
        logic sgt;   // mask bit 3
        logic eq;    // mask bit 2
        logic ult;   // mask bit 1
        logic ugt;   // mask bit 0
    } rel_flags_t;

    typedef struct packed {
        logic              done;
        logic              trap;
        logic [CODE_W-1:0] cause;
    } trap_state_t;

endpackage

// File: rtl/trap_operand_view.sv
module trap_operand_view #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [XLEN-1:0] raw_i,
    input  logic            dword_i,
    output logic [XLEN-1:0] ukey_o,
    output logic [XLEN-1:0] skey_o
);
    localparam int HI_W = XLEN - WLEN;

    logic [XLEN-1:0] sext;
    logic [XLEN-1:0] zext;

    always_comb begin
        zext = {{HI_W{1'b0}}, raw_i[WLEN-1:0]};
        sext = {{HI_W{raw_i[WLEN-1]}}, raw_i[WLEN-1:0]};
        ukey_o = dword_i ? raw_i : zext;
        // Inverting the sign bit maps signed order onto unsigned order.
        skey_o = dword_i ? raw_i : sext;
        skey_o[XLEN-1] = ~skey_o[XLEN-1];
    end
endmodule

// File: rtl/trap_magnitude_cmp.sv
module trap_magnitude_cmp #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            lt_o,
    output logic            eq_o,
    output logic            gt_o
);
    always_comb begin
        lt_o = a_i < b_i;
        eq_o = a_i == b_i;
        gt_o = a_i > b_i;
    end
endmodule

// File: rtl/trap_mask_eval.sv
module trap_mask_eval
    import trap_cmp_pkg::*;
(
    input  rel_flags_t        flags_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              hit_o
);
    logic [MASK_W-1:0] sel;

    always_comb begin
        sel   = mask_i & MASK_W'(flags_i);
        hit_o = |sel;
    end
endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
    import trap_cmp_pkg::*;
#(
    parameter int                XLEN      = 64,
    parameter int                WLEN      = 32,
    parameter logic [CODE_W-1:0] TRAP_CODE = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              dword_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    output logic              done_o,
    output logic              trap_o,
    output logic [CODE_W-1:0] cause_o
);
    localparam int NOPS = 2;

    logic [XLEN-1:0] ops  [NOPS];
    logic [XLEN-1:0] ukey [NOPS];
    logic [XLEN-1:0] skey [NOPS];

    assign ops[0] = opa_i;
    assign ops[1] = opb_i;

    for (genvar i = 0; i < NOPS; i++) begin : g_view
        trap_operand_view #(.XLEN(XLEN), .WLEN(WLEN)) u_view (
            .raw_i   (ops[i]),
            .dword_i (dword_i),
            .ukey_o  (ukey[i]),
            .skey_o  (skey[i])
        );
    end

    logic s_lt, s_eq, s_gt;
    logic u_lt, u_eq, u_gt;

    trap_magnitude_cmp #(.XLEN(XLEN)) u_scmp (
        .a_i (skey[0]), .b_i (skey[1]),
        .lt_o(s_lt), .eq_o(s_eq), .gt_o(s_gt)
    );

    trap_magnitude_cmp #(.XLEN(XLEN)) u_ucmp (
        .a_i (ukey[0]), .b_i (ukey[1]),
        .lt_o(u_lt), .eq_o(u_eq), .gt_o(u_gt)
    );

    rel_flags_t flags;
    logic       hit;

    always_comb begin
        flags.slt = s_lt;
        flags.sgt = s_gt;
        flags.eq  = u_eq;
        flags.ult = u_lt;
        flags.ugt = u_gt;
    end

    trap_mask_eval u_eval (
        .flags_i (flags),
        .mask_i  (mask_i),
        .hit_o   (hit)
    );

    trap_state_t st_d, st_q;

    always_comb begin
        st_d.done  = valid_i;
        st_d.trap  = valid_i & hit;
        st_d.cause = (valid_i & hit) ? TRAP_CODE : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o  = st_q.done;
    assign trap_o  = st_q.trap;
    assign cause_o = st_q.cause;

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);
    assert_eq_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_eq == u_eq);
    assert_order_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({s_lt, s_eq, s_gt}) == 1 && $countones({u_lt, u_eq, u_gt}) == 1);
    assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mask_i == '0) |=> !trap_o);
    assert_full_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mask_i == '1) |=> trap_o);
    assert_trap_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (done_o && cause_o == TRAP_CODE));
    assert_cause_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> cause_o == '0);
endmodule

// File: tb/trap_cmp_unit_bench.sv
module trap_cmp_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] CODE = 4'h3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic        dword_i;
    logic [4:0]  mask_i;
    logic [63:0] opa_i, opb_i;
    logic        done_o, trap_o;
    logic [3:0]  cause_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_cmp_unit u_trap_cmp_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dword_i(dword_i),
        .mask_i(mask_i), .opa_i(opa_i), .opb_i(opb_i),
        .done_o(done_o), .trap_o(trap_o), .cause_o(cause_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pick(input int k, input bit wide);
        logic [63:0] v;
        case (k)
            0: v = 64'h0;
            1: v = 64'h1;
            2: v = 64'h2;
            3: v = wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF;
            4: v = wide ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
            5: v = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
            6: v = wide ? 64'hFFFF_FFFF_FFFF_FFFE : 64'hFFFF_FFFE;
            default: v = wide ? 64'h1234_5678_9ABC_DEF0 : 64'h9ABC_DEF0;
        endcase
        return v;
    endfunction

    function automatic bit model(input logic [63:0] a, input logic [63:0] b,
                                 input bit wide, input logic [4:0] m);
        longint      sa, sb;
        logic [63:0] ua, ub;
        if (wide) begin
            sa = longint'(a); sb = longint'(b); ua = a; ub = b;
        end else begin
            sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
            ua = {32'b0, a[31:0]}; ub = {32'b0, b[31:0]};
        end
        return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
               (m[1] && ua < ub) || (m[0] && ua > ub);
    endfunction

    task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                           input bit wide, input logic [4:0] m, input string req);
        bit exp;
        exp = model(a, b, wide, m);
        @(negedge clk);
        valid_i = 1'b1; dword_i = wide; mask_i = m; opa_i = a; opb_i = b;
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        check({req, " R1 done"}, 64'(done_o), 64'd1);
        check(req, 64'(trap_o), 64'(exp));
        check({req, " R10 cause"}, 64'(cause_o), exp ? 64'(CODE) : 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] noise;
        rst_n = 1'b0; valid_i = 1'b1; dword_i = 1'b1; mask_i = 5'h1F;
        opa_i = '0; opb_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 done", 64'(done_o), 64'd0);
        check("R11 trap", 64'(trap_o), 64'd0);
        check("R11 cause", 64'(cause_o), 64'd0);
        valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 64'(done_o), 64'd0);

        // Single relations on directed pairs (R2..R5)
        run_one(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 5'h10, "R2 slt");
        run_one(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 5'h10, "R2 slt-no");
        run_one(64'h5, 64'h8000_0000_0000_0000, 1'b1, 5'h08, "R3 sgt");
        run_one(64'h77, 64'h77, 1'b1, 5'h04, "R4 eq");
        run_one(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 5'h02, "R5 ult");
        run_one(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 5'h01, "R5 ugt");
        // Word mode: upper halves conflict with lower-half result (R7)
        run_one(64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b0, 5'h10, "R7 word slt");
        run_one(64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 1'b0, 5'h04, "R7 word eq");
        // Doubleword: only upper halves differ (R8)
        run_one(64'h0000_0001_0000_0005, 64'h0000_0000_0000_0005, 1'b1, 5'h01, "R8 dword ugt");
        run_one(64'h0000_0001_0000_0005, 64'h0000_0000_0000_0005, 1'b1, 5'h04, "R8 dword neq");

        // Sweep: all masks, both widths, boundary operands (R6, R9)
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    for (int m = 0; m < 32; m++) begin
                        logic [63:0] a, b;
                        a = pick(i, w[0]);
                        b = pick(j, w[0]);
                        if (w == 0) begin
                            noise = {32'(i * 32'h9E37_79B9 + m), 32'h0};
                            a = a | noise;
                            b = b | {32'(j * 32'h85EB_CA6B ^ m), 32'h0};
                        end
                        if (m == 0)
                            run_one(a, b, w[0], 5'(m), "R9 zero");
                        else if (m == 31)
                            run_one(a, b, w[0], 5'(m), "R9 full");
                        else
                            run_one(a, b, w[0], 5'(m), w == 0 ? "R6 R7 sweep" : "R6 R8 sweep");
                    end
                end
            end
        end

        // Strobe dropped: outputs clear the cycle after (R1, R10)
        @(posedge clk);
        @(negedge clk);
        check("R1 drop", 64'(done_o), 64'd0);
        check("R10 drop trap", 64'(trap_o), 64'd0);
        check("R10 drop cause", 64'(cause_o), 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule